// File: doc/BRIEF.md
# Mode-Banked Register File

This block stores the general-purpose registers of a 32-bit processor core whose register view changes with the operating mode. Two combinational read ports and one clocked write port take a logical register index (0 to 15) together with the current mode, and the block picks the physical storage behind that index. Low registers are common to every mode. The upper general registers are replaced by a private set in fast-interrupt mode. The stack pointer and link register have a private copy in each exception mode. The program counter lives outside the block, so index 15 is a dead slot here.

The block also holds the current status word and one saved status word for each exception mode. An exception sequencer uses two extra write ports to load the link register and the saved status word of the mode it is about to enter, while the current mode still selects what the normal ports see. When such a write and a normal write hit the same storage in one cycle, the sequencer's write wins.

Top module: `bank_regfile`

## Requirements
- R1: After the active-low asynchronous reset, every readable register, the status word and every saved status word read as zero.
- R2: Logical indices 0 to 7 map to one physical set shared by all modes; a value written in any mode is read back at the same index in every mode.
- R3: Indices 8 to 12 select a private set only in fast-interrupt mode (mode code 1); every other mode reads and writes one common set.
- R4: Indices 13 and 14 select a private copy in each exception mode (codes 1 fast-interrupt, 2 supervisor, 3 abort, 4 interrupt, 5 undefined); mode code 0 (user/system) has its own copy.
- R5: Index 15 always reads as zero on both read ports and a write to it changes nothing.
- R6: Each exception mode has its own saved status word; spsr_o shows the current mode's copy, and in user/system mode spsr_o equals cpsr_o and spsr_we_i has no effect on any saved word.
- R7: Writes take effect at the rising clock edge; a read of the register being written in the same cycle returns the old value.
- R8: exc_lr_we_i loads index 14 of the mode given by exc_mode_i and exc_spsr_we_i loads that mode's saved status word, independent of mode_i; when exc_mode_i selects user/system (codes 0, 6, 7) these ports change nothing.
- R9: When the exception port and the normal port write the same physical register or saved word in one cycle, the exception port's data is kept.
- R10: Mode codes 6 and 7 behave exactly as code 0 for banking and saved-word access.
- R11: The status word cpsr_o is shared by all modes and changes only at a clock edge with cpsr_we_i high, taking cpsr_wdata_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Current mode code |
| rd_a_idx_i | input | 4 | Read port A logical index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B logical index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Normal write enable |
| wr_idx_i | input | 4 | Normal write logical index |
| wr_data_i | input | 32 | Normal write data |
| cpsr_we_i | input | 1 | Status word write enable |
| cpsr_wdata_i | input | 32 | Status word write data |
| cpsr_o | output | 32 | Current status word |
| spsr_we_i | input | 1 | Saved status write enable for current mode |
| spsr_wdata_i | input | 32 | Saved status write data |
| spsr_o | output | 32 | Saved status word of the current mode |
| exc_mode_i | input | 3 | Target mode of the exception ports |
| exc_lr_we_i | input | 1 | Write enable for the target mode's index 14 |
| exc_lr_data_i | input | 32 | Data for the target mode's index 14 |
| exc_spsr_we_i | input | 1 | Write enable for the target mode's saved status |
| exc_spsr_data_i | input | 32 | Data for the target mode's saved status |

## Verification
A write routed to the wrong bank leaves the intended copy stale and corrupts another mode's copy; neither shows at the ports until some later read selects that index in the affected mode, so the bench reads both ports in a freshly drawn mode every cycle and compares against a reference model, catching such an error on the first read that touches either copy. A lost priority between the two write ports shows one cycle after the collision, on the next read of that link register or saved word. A saved-word fault in user mode is visible at once, since spsr_o must mirror cpsr_o in that same cycle.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam logic [2:0] MD_USR = 3'd0;
  localparam logic [2:0] MD_FIQ = 3'd1;
  localparam logic [2:0] MD_SVC = 3'd2;
  localparam logic [2:0] MD_ABT = 3'd3;
  localparam logic [2:0] MD_IRQ = 3'd4;
  localparam logic [2:0] MD_UND = 3'd5;

  localparam int NUM_XMODES  = 5;
  localparam int NUM_SHARED  = 8;
  localparam int NUM_FIQ_HI  = 5;
  localparam int FIQ_HI_BASE = 15;
  localparam int SP_BASE     = FIQ_HI_BASE + NUM_FIQ_HI;
  localparam int NPHYS       = SP_BASE + 2 * NUM_XMODES;
  localparam int PHYS_W      = $clog2(NPHYS);

  function automatic logic [2:0] norm_mode(logic [2:0] m);
    return (m > MD_UND) ? MD_USR : m;
  endfunction

  function automatic logic [PHYS_W-1:0] phys_of(logic [2:0] m, logic [3:0] idx);
    int n;
    int i;
    n = int'(norm_mode(m));
    i = int'(idx);
    if (i < NUM_SHARED) return PHYS_W'(i);
    if (i < NUM_SHARED + NUM_FIQ_HI)
      return (n == int'(MD_FIQ)) ? PHYS_W'(FIQ_HI_BASE + i - NUM_SHARED) : PHYS_W'(i);
    if (i < 15)
      return (n == int'(MD_USR)) ? PHYS_W'(i) : PHYS_W'(SP_BASE + 2 * (n - 1) + i - 13);
    return '0;
  endfunction
endpackage

// File: rtl/brf_map.sv
module brf_map
  import brf_pkg::*;
(
  input  logic [2:0]        mode_i,
  input  logic [3:0]        idx_i,
  output logic [PHYS_W-1:0] phys_o,
  output logic              hit_o
);
  assign phys_o = phys_of(mode_i, idx_i);
  assign hit_o  = (idx_i != 4'd15);
endmodule

// File: rtl/brf_store.sv
module brf_store
  import brf_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int DEPTH = NPHYS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_n_i,
  input  logic [PHYS_W-1:0] wa_n_i,
  input  logic [XLEN-1:0]   wd_n_i,
  input  logic              we_x_i,
  input  logic [PHYS_W-1:0] wa_x_i,
  input  logic [XLEN-1:0]   wd_x_i,
  input  logic [PHYS_W-1:0] ra_a_i,
  output logic [XLEN-1:0]   rd_a_o,
  input  logic [PHYS_W-1:0] ra_b_i,
  output logic [XLEN-1:0]   rd_b_o
);
  logic [XLEN-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[g] <= '0;
      else if (we_x_i && wa_x_i == PHYS_W'(g))       mem_q[g] <= wd_x_i;  // exception port wins
      else if (we_n_i && wa_n_i == PHYS_W'(g))       mem_q[g] <= wd_n_i;
    end
  end

  assign rd_a_o = (int'(ra_a_i) < DEPTH) ? mem_q[ra_a_i] : '0;
  assign rd_b_o = (int'(ra_b_i) < DEPTH) ? mem_q[ra_b_i] : '0;
endmodule

// File: rtl/brf_psr.sv
module brf_psr
  import brf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      mode_i,
  input  logic            cpsr_we_i,
  input  logic [XLEN-1:0] cpsr_wd_i,
  input  logic            spsr_we_i,
  input  logic [XLEN-1:0] spsr_wd_i,
  input  logic [2:0]      xmode_i,
  input  logic            xspsr_we_i,
  input  logic [XLEN-1:0] xspsr_wd_i,
  output logic [XLEN-1:0] cpsr_o,
  output logic [XLEN-1:0] spsr_o
);
  logic [XLEN-1:0] cpsr_q;
  logic [XLEN-1:0] spsr_q [1:NUM_XMODES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cpsr_q <= '0;
    else if (cpsr_we_i) cpsr_q <= cpsr_wd_i;
  end

  for (genvar k = 1; k <= NUM_XMODES; k++) begin : g_spsr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 spsr_q[k] <= '0;
      else if (xspsr_we_i && xmode_i == 3'(k))     spsr_q[k] <= xspsr_wd_i;
      else if (spsr_we_i && mode_i == 3'(k))       spsr_q[k] <= spsr_wd_i;
    end
  end

  always_comb begin
    spsr_o = cpsr_q;  // user/system has no saved word
    for (int k = 1; k <= NUM_XMODES; k++)
      if (mode_i == 3'(k)) spsr_o = spsr_q[k];
  end

  assign cpsr_o = cpsr_q;
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import brf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      mode_i,
  input  logic [3:0]      rd_a_idx_i,
  output logic [XLEN-1:0] rd_a_data_o,
  input  logic [3:0]      rd_b_idx_i,
  output logic [XLEN-1:0] rd_b_data_o,
  input  logic            wr_en_i,
  input  logic [3:0]      wr_idx_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            cpsr_we_i,
  input  logic [XLEN-1:0] cpsr_wdata_i,
  output logic [XLEN-1:0] cpsr_o,
  input  logic            spsr_we_i,
  input  logic [XLEN-1:0] spsr_wdata_i,
  output logic [XLEN-1:0] spsr_o,
  input  logic [2:0]      exc_mode_i,
  input  logic            exc_lr_we_i,
  input  logic [XLEN-1:0] exc_lr_data_i,
  input  logic            exc_spsr_we_i,
  input  logic [XLEN-1:0] exc_spsr_data_i
);
  logic [2:0]        cur_mode, xmode;
  logic [PHYS_W-1:0] pa_a, pa_b, pa_w, pa_x;
  logic              hit_a, hit_b, hit_w, hit_x;
  logic [XLEN-1:0]   raw_a, raw_b;
  logic              x_valid;

  assign cur_mode = norm_mode(mode_i);
  assign xmode    = norm_mode(exc_mode_i);
  assign x_valid  = (xmode != MD_USR);

  brf_map u_map_a (.mode_i(cur_mode), .idx_i(rd_a_idx_i), .phys_o(pa_a), .hit_o(hit_a));
  brf_map u_map_b (.mode_i(cur_mode), .idx_i(rd_b_idx_i), .phys_o(pa_b), .hit_o(hit_b));
  brf_map u_map_w (.mode_i(cur_mode), .idx_i(wr_idx_i),   .phys_o(pa_w), .hit_o(hit_w));
  brf_map u_map_x (.mode_i(xmode),    .idx_i(4'd14),      .phys_o(pa_x), .hit_o(hit_x));

  brf_store #(.XLEN(XLEN)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_n_i (wr_en_i && hit_w),
    .wa_n_i (pa_w),
    .wd_n_i (wr_data_i),
    .we_x_i (exc_lr_we_i && hit_x && x_valid),
    .wa_x_i (pa_x),
    .wd_x_i (exc_lr_data_i),
    .ra_a_i (pa_a),
    .rd_a_o (raw_a),
    .ra_b_i (pa_b),
    .rd_b_o (raw_b)
  );

  assign rd_a_data_o = hit_a ? raw_a : '0;
  assign rd_b_data_o = hit_b ? raw_b : '0;

  brf_psr #(.XLEN(XLEN)) u_psr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (cur_mode),
    .cpsr_we_i  (cpsr_we_i),
    .cpsr_wd_i  (cpsr_wdata_i),
    .spsr_we_i  (spsr_we_i),
    .spsr_wd_i  (spsr_wdata_i),
    .xmode_i    (xmode),
    .xspsr_we_i (exc_spsr_we_i && x_valid),
    .xspsr_wd_i (exc_spsr_data_i),
    .cpsr_o     (cpsr_o),
    .spsr_o     (spsr_o)
  );
endmodule

// File: rtl/brf_checker.sv
module brf_checker #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [2:0]      mode_i,
  input logic [3:0]      rd_a_idx_i,
  input logic [XLEN-1:0] rd_a_data_o,
  input logic            wr_en_i,
  input logic [3:0]      wr_idx_i,
  input logic [XLEN-1:0] wr_data_i,
  input logic            cpsr_we_i,
  input logic [XLEN-1:0] cpsr_o,
  input logic [XLEN-1:0] spsr_o,
  input logic [2:0]      exc_mode_i,
  input logic            exc_lr_we_i,
  input logic [XLEN-1:0] exc_lr_data_i
);
  logic cur_user;
  assign cur_user = (mode_i == 3'd0) || (mode_i > 3'd5);

  a_r2_shared_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i < 4'd8) ##1 (rd_a_idx_i == $past(wr_idx_i))
    |-> rd_a_data_o == $past(wr_data_i));

  a_r5_pc_slot_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_idx_i == 4'd15) |-> rd_a_data_o == '0);

  a_r6_user_spsr_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_user |-> spsr_o == cpsr_o);

  // R8 and R9: exception link write lands in its mode and beats a colliding write
  a_r8_exc_lr_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_lr_we_i && exc_mode_i != 3'd0 && exc_mode_i < 3'd6)
    ##1 (mode_i == $past(exc_mode_i) && rd_a_idx_i == 4'd14)
    |-> rd_a_data_o == $past(exc_lr_data_i));

  a_r11_cpsr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpsr_we_i |=> $stable(cpsr_o));
endmodule

bind bank_regfile brf_checker #(.XLEN(XLEN)) u_chk (.*);

// File: tb/bank_regfile_bench.sv
`timescale 1ns/1ps
module bank_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = '0, xm = '0;
  logic [3:0]  ra = '0, rb = '0, wi = '0;
  logic [31:0] rd_a, rd_b, cpsr, spsr;
  logic        we = 0, cwe = 0, swe = 0, xlw = 0, xsw = 0;
  logic [31:0] wd = '0, cwd = '0, swd = '0, xld = '0, xsd = '0;

  always #5 clk = ~clk;

  bank_regfile u_bank_regfile (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .rd_a_idx_i(ra), .rd_a_data_o(rd_a), .rd_b_idx_i(rb), .rd_b_data_o(rd_b),
    .wr_en_i(we), .wr_idx_i(wi), .wr_data_i(wd),
    .cpsr_we_i(cwe), .cpsr_wdata_i(cwd), .cpsr_o(cpsr),
    .spsr_we_i(swe), .spsr_wdata_i(swd), .spsr_o(spsr),
    .exc_mode_i(xm), .exc_lr_we_i(xlw), .exc_lr_data_i(xld),
    .exc_spsr_we_i(xsw), .exc_spsr_data_i(xsd));

  // reference model: logical views kept as plain arrays
  logic [31:0] m_lo [8];
  logic [31:0] m_uh [5];
  logic [31:0] m_fq [5];
  logic [31:0] m_sl [6][2];   // [mode][0=r13,1=r14], mode 0 = user copy
  logic [31:0] m_sp [6];
  logic [31:0] m_cpsr;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string phase = "";

  function automatic int nm(logic [2:0] m);
    return (m > 3'd5) ? 0 : int'(m);
  endfunction

  function automatic logic [31:0] mread(logic [2:0] m, logic [3:0] i);
    int n = nm(m);
    if (i == 4'd15) return '0;
    if (i < 4'd8) return m_lo[i];
    if (i < 4'd13) return (n == 1) ? m_fq[i-8] : m_uh[i-8];
    return m_sl[n][i-13];
  endfunction

  task automatic mwrite(logic [2:0] m, logic [3:0] i, logic [31:0] v);
    int n = nm(m);
    if (i == 4'd15) return;
    if (i < 4'd8) m_lo[i] = v;
    else if (i < 4'd13) begin
      if (n == 1) m_fq[i-8] = v; else m_uh[i-8] = v;
    end else m_sl[n][i-13] = v;
  endtask

  function automatic string rtag(logic [3:0] i);
    if (phase != "") return phase;
    if (i < 4'd8) return "R2";
    if (i < 4'd13) return "R3";
    if (i < 4'd15) return "R4";
    return "R5";
  endfunction

  function automatic string ptag(string t);
    return (phase != "") ? phase : t;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (mode %0d)", tag, what, got, exp, mode);
    end
  endtask

  // compare before the edge, then advance model with the edge
  task automatic step();
    #1;
    chk(rtag(ra), "read A", rd_a, mread(mode, ra));
    chk(rtag(rb), "read B", rd_b, mread(mode, rb));
    chk(ptag("R11"), "cpsr", cpsr, m_cpsr);
    chk(ptag("R6"), "spsr", spsr, (nm(mode) == 0) ? m_cpsr : m_sp[nm(mode)]);
    @(posedge clk);
    if (we) mwrite(mode, wi, wd);
    if (xlw && nm(xm) != 0) m_sl[nm(xm)][1] = xld;
    if (swe && nm(mode) != 0) m_sp[nm(mode)] = swd;
    if (xsw && nm(xm) != 0) m_sp[nm(xm)] = xsd;
    if (cwe) m_cpsr = cwd;
    @(negedge clk);
    we = 0; cwe = 0; swe = 0; xlw = 0; xsw = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_lo[i] = '0;
    for (int i = 0; i < 5; i++) begin m_uh[i] = '0; m_fq[i] = '0; end
    for (int k = 0; k < 6; k++) begin m_sl[k][0] = '0; m_sl[k][1] = '0; m_sp[k] = '0; end
    m_cpsr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values across all modes
    phase = "R1";
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 16; i += 2) begin
        mode = 3'(m); ra = 4'(i); rb = 4'(i + 1); step();
      end

    // R7: same-cycle read of the written register returns the old value
    phase = "R7";
    mode = 3'd2; ra = 4'd3; rb = 4'd14; we = 1; wi = 4'd3; wd = 32'hA5A5_0003; step();
    ra = 4'd14; rb = 4'd3; we = 1; wi = 4'd14; wd = 32'h0000_5C14; step();
    step();

    // R8: exception port writes another mode's link and saved word
    phase = "R8";
    mode = 3'd0; xm = 3'd4; xlw = 1; xld = 32'h1111_4E14; xsw = 1; xsd = 32'h0000_00D3;
    ra = 4'd14; rb = 4'd13; step();
    mode = 3'd4; step();
    mode = 3'd0; xm = 3'd7; xlw = 1; xld = 32'hDEAD_0007; xsw = 1; xsd = 32'hDEAD_0017; step();
    step();

    // R9: collision on the same link register and saved word
    phase = "R9";
    mode = 3'd3; ra = 4'd14; xm = 3'd3;
    we = 1; wi = 4'd14; wd = 32'h0BAD_0BAD; xlw = 1; xld = 32'h600D_0003;
    swe = 1; swd = 32'h0BAD_5555; xsw = 1; xsd = 32'h600D_5555; step();
    step();

    // R10: codes 6 and 7 act as user/system
    phase = "R10";
    mode = 3'd6; we = 1; wi = 4'd13; wd = 32'h5700_0013; swe = 1; swd = 32'hFFFF_0006; step();
    mode = 3'd0; ra = 4'd13; step();
    mode = 3'd7; we = 1; wi = 4'd9; wd = 32'h0707_0009; ra = 4'd9; step();
    mode = 3'd1; step();
    mode = 3'd0; step();

    // R6: saved word ignores user-mode writes
    phase = "R6";
    mode = 3'd0; cwe = 1; cwd = 32'h0000_0010; swe = 1; swd = 32'h1234_0000; step();
    step();
    mode = 3'd2; step();

    // random sweep; tags come from the index or port
    phase = "";
    for (int t = 0; t < 4000; t++) begin
      mode = 3'($urandom_range(0, 7));
      ra = 4'($urandom); rb = 4'($urandom);
      we = ($urandom_range(0, 3) != 0); wi = 4'($urandom); wd = $urandom;
      cwe = ($urandom_range(0, 7) == 0); cwd = $urandom;
      swe = ($urandom_range(0, 5) == 0); swd = $urandom;
      xm = 3'($urandom_range(0, 7));
      xlw = ($urandom_range(0, 5) == 0); xld = $urandom;
      xsw = ($urandom_range(0, 5) == 0); xsd = $urandom;
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule